// File: doc/BRIEF.md
# Circular Buffer Data Address Generator

This block produces addresses for indirect data memory accesses. It holds sixteen circular buffer contexts in each of two banks, a primary bank and a secondary bank, so thirty-two buffers in total. Each context keeps four registers: an index, a signed modifier, a base and a length. When a context is accessed, the block presents its current index as the memory address. It then adds the modifier to the index. If that step carries the index past either end of the buffer window, the block folds it back inside the window, so software never has to test bounds. A buffer may start at any address and may have any length. Alignment is not required, and the length need not be a power of two.

A bank-select level chooses which bank serves register writes and accesses. The choice is registered and applies from the following cycle. One bank can therefore hold a second set of buffer states while the other bank is in use. A SIMD flag on an access marks a paired transfer. The block then also presents the neighbouring address, one above the generated one.

Top module: `cbuf_agen`

## Requirements
- R1: After reset all outputs are low. Every context register in both banks is zero, and the primary bank (bank 0) is active.
- R2: An access with `accEn` high in cycle t drives `addrValid` high in cycle t+1, with `addrOut` equal to the context's index as it was before the access. A cycle with `accEn` low gives `addrValid` low in the next cycle.
- R3: After each access, the index becomes the index plus the modifier. The modifier is treated as a two's-complement signed value of `ADDR_W` bits.
- R4: If the modified index is equal to or greater than base plus length, the length is subtracted from it.
- R5: If the modified index is below the base, the length is added to it.
- R6: A context whose length is zero never wraps. Its index moves linearly by the modifier.
- R7: Register writes use `wrField` codes 0 = index, 1 = modifier, 2 = base, 3 = length. A base write also loads the index with the same value.
- R8: The base may be any address (for example 0x1003) and the length any value (for example 7). Wrapping then stays within [base, base+length).
- R9: `bankSel` is sampled at each clock edge, and the sampled value picks the bank for writes and accesses from the next cycle onward. The contexts of the bank that is not selected keep their values.
- R10: An access with `simdEn` high drives `pairValid` high one cycle later, with `pairAddr` equal to `addrOut` + 1. An access with `simdEn` low gives `pairValid` low.
- R11: A write and an access to the same register in the same cycle leave the written value. The access still outputs the old index.
- R12: A modifier whose magnitude equals the length returns the index to the same address on every access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankSel | input | 1 | Bank choice: 0 primary, 1 secondary, effective next cycle |
| wrEn | input | 1 | Register write strobe |
| wrField | input | 2 | Register chosen for the write (0 index, 1 modifier, 2 base, 3 length) |
| wrCtx | input | 4 | Context number for the write |
| wrData | input | ADDR_W | Write value |
| accEn | input | 1 | Access request |
| accCtx | input | 4 | Context number for the access |
| simdEn | input | 1 | Marks the access as a paired transfer |
| addrValid | output | 1 | Address output valid |
| addrOut | output | ADDR_W | Generated address |
| pairValid | output | 1 | Paired address valid |
| pairAddr | output | ADDR_W | Neighbour address for the paired transfer |

## Verification
A corrupted index, modifier, base or length is not visible until that context is next accessed. At that point `addrOut` shows it in the following cycle, and the error stays in every address after it. A faulty wrap comparison first shows up on the access after the step that crosses the window edge, as an address outside the window. A wrong bank latch shows up as an address taken from the other bank's context. The bench therefore walks each sequence across its wrap points and reads both banks back after switching between them.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  localparam int CB_NUM_CTX = 16;
  localparam int CB_CTX_W   = $clog2(CB_NUM_CTX);
  localparam int CB_BANKS   = 2;

  typedef enum logic [1:0] {
    FLD_INDEX  = 2'd0,
    FLD_MODIFY = 2'd1,
    FLD_BASE   = 2'd2,
    FLD_LENGTH = 2'd3
  } fieldSel_e;

  typedef struct packed {
    logic                doWrite;
    logic                doAccess;
    logic                simd;
    logic                bank;
    fieldSel_e           field;
    logic [CB_CTX_W-1:0] wrCtx;
    logic [CB_CTX_W-1:0] accCtx;
  } ctrlStrb_s;
endpackage

// File: rtl/cbuf_ctrl.sv
module cbuf_ctrl
  import cbuf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                bankSel,
  input  logic                wrEn,
  input  logic [1:0]          wrField,
  input  logic [CB_CTX_W-1:0] wrCtx,
  input  logic                accEn,
  input  logic [CB_CTX_W-1:0] accCtx,
  input  logic                simdEn,
  output ctrlStrb_s           strb
);
  logic activeBank;

  always_ff @(posedge clk) begin
    if (!rstN) activeBank <= 1'b0;
    else       activeBank <= bankSel;
  end

  always_comb begin
    strb.doWrite  = wrEn;
    strb.doAccess = accEn;
    strb.simd     = simdEn;
    strb.bank     = activeBank;
    strb.field    = fieldSel_e'(wrField);
    strb.wrCtx    = wrCtx;
    strb.accCtx   = accCtx;
  end
endmodule

// File: rtl/cbuf_datapath.sv
module cbuf_datapath
  import cbuf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_s         strb,
  input  logic [ADDR_W-1:0] wrData,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic              pairValid,
  output logic [ADDR_W-1:0] pairAddr
);
  localparam int EXT_W = ADDR_W + 2;

  logic [ADDR_W-1:0] idxReg  [CB_BANKS][CB_NUM_CTX];
  logic [ADDR_W-1:0] modReg  [CB_BANKS][CB_NUM_CTX];
  logic [ADDR_W-1:0] baseReg [CB_BANKS][CB_NUM_CTX];
  logic [ADDR_W-1:0] lenReg  [CB_BANKS][CB_NUM_CTX];

  logic [ADDR_W-1:0] curIdx, curMod, curBase, curLen, nextIdx;
  logic signed [EXT_W-1:0] stepSum, upperEnd, lowerEnd;

  // Post-modify with fold-back into [base, base+len)
  always_comb begin
    curIdx   = idxReg[strb.bank][strb.accCtx];
    curMod   = modReg[strb.bank][strb.accCtx];
    curBase  = baseReg[strb.bank][strb.accCtx];
    curLen   = lenReg[strb.bank][strb.accCtx];
    stepSum  = $signed({2'b00, curIdx}) + $signed({{2{curMod[ADDR_W-1]}}, curMod});
    lowerEnd = $signed({2'b00, curBase});
    upperEnd = $signed({2'b00, curBase}) + $signed({2'b00, curLen});
    nextIdx  = stepSum[ADDR_W-1:0];
    if (curLen != '0) begin
      if (stepSum >= upperEnd)     nextIdx = stepSum[ADDR_W-1:0] - curLen;
      else if (stepSum < lowerEnd) nextIdx = stepSum[ADDR_W-1:0] + curLen;
    end
  end

  // Context storage; a write is placed after the update so it wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < CB_BANKS; b++) begin
        for (int c = 0; c < CB_NUM_CTX; c++) begin
          idxReg[b][c]  <= '0;
          modReg[b][c]  <= '0;
          baseReg[b][c] <= '0;
          lenReg[b][c]  <= '0;
        end
      end
    end else begin
      if (strb.doAccess) idxReg[strb.bank][strb.accCtx] <= nextIdx;
      if (strb.doWrite) begin
        case (strb.field)
          FLD_INDEX:  idxReg[strb.bank][strb.wrCtx] <= wrData;
          FLD_MODIFY: modReg[strb.bank][strb.wrCtx] <= wrData;
          FLD_BASE: begin
            baseReg[strb.bank][strb.wrCtx] <= wrData;
            idxReg[strb.bank][strb.wrCtx]  <= wrData;
          end
          default:    lenReg[strb.bank][strb.wrCtx] <= wrData;
        endcase
      end
    end
  end

  // Output stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      pairValid <= 1'b0;
      addrOut   <= '0;
      pairAddr  <= '0;
    end else begin
      addrValid <= strb.doAccess;
      pairValid <= strb.doAccess & strb.simd;
      if (strb.doAccess) begin
        addrOut  <= curIdx;
        pairAddr <= curIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
  import cbuf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bankSel,
  input  logic                wrEn,
  input  logic [1:0]          wrField,
  input  logic [CB_CTX_W-1:0] wrCtx,
  input  logic [ADDR_W-1:0]   wrData,
  input  logic                accEn,
  input  logic [CB_CTX_W-1:0] accCtx,
  input  logic                simdEn,
  output logic                addrValid,
  output logic [ADDR_W-1:0]   addrOut,
  output logic                pairValid,
  output logic [ADDR_W-1:0]   pairAddr
);
  ctrlStrb_s strb;

  cbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .wrEn(wrEn), .wrField(wrField),
    .wrCtx(wrCtx), .accEn(accEn), .accCtx(accCtx), .simdEn(simdEn), .strb(strb)
  );

  cbuf_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .addrValid(addrValid), .addrOut(addrOut),
    .pairValid(pairValid), .pairAddr(pairAddr)
  );
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accEn,
  input logic              simdEn,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrOut,
  input logic              pairValid,
  input logic [ADDR_W-1:0] pairAddr
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    accEn |=> addrValid);
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |=> !addrValid);
  assert_pair_on_simd_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && simdEn) |=> pairValid);
  assert_no_pair_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !simdEn) |=> !pairValid);
  assert_pair_neighbour_R10: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (addrValid && pairAddr == addrOut + 1'b1));
endmodule

bind cbuf_agen cbuf_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .accEn(accEn), .simdEn(simdEn),
  .addrValid(addrValid), .addrOut(addrOut),
  .pairValid(pairValid), .pairAddr(pairAddr)
);

// File: tb/cbuf_agen_tb.sv
module cbuf_agen_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bankSel = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrField = '0;
  logic [3:0]    wrCtx = '0;
  logic [AW-1:0] wrData = '0;
  logic          accEn = 1'b0;
  logic [3:0]    accCtx = '0;
  logic          simdEn = 1'b0;
  logic          addrValid, pairValid;
  logic [AW-1:0] addrOut, pairAddr;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cbuf_agen #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .wrEn(wrEn), .wrField(wrField),
    .wrCtx(wrCtx), .wrData(wrData), .accEn(accEn), .accCtx(accCtx), .simdEn(simdEn),
    .addrValid(addrValid), .addrOut(addrOut), .pairValid(pairValid), .pairAddr(pairAddr)
  );

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] fld, logic [3:0] ctx, logic [AW-1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrField = fld; wrCtx = ctx; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCtx(logic [3:0] ctx, logic [AW-1:0] base, logic [AW-1:0] len,
                        logic [AW-1:0] mdf);
    wrReg(2'd2, ctx, base);
    wrReg(2'd3, ctx, len);
    wrReg(2'd1, ctx, mdf);
  endtask

  // Access and compare the address shown in the next cycle
  task automatic access(string tag, logic [3:0] ctx, logic [AW-1:0] expAddr);
    @(negedge clk);
    accEn = 1'b1; accCtx = ctx; simdEn = 1'b0;
    @(negedge clk);
    accEn = 1'b0;
    check({tag, " valid"}, {31'd0, addrValid}, 32'd1);
    check(tag, addrOut, expAddr);
  endtask

  task automatic setBank(logic b);
    @(negedge clk);
    bankSel = b;
  endtask

  task automatic testReset();
    check("R1 addrValid", {31'd0, addrValid}, 32'd0);
    check("R1 pairValid", {31'd0, pairValid}, 32'd0);
    check("R1 addrOut", addrOut, 32'd0);
    access("R1 ctx0 zero index", 4'd0, 32'd0);
    access("R1 ctx0 zero modifier", 4'd0, 32'd0);
  endtask

  task automatic testLinear();
    setCtx(4'd1, 32'h100, 32'd0, 32'd4);
    access("R7 base loads index", 4'd1, 32'h100);
    access("R3 post-modify", 4'd1, 32'h104);
    access("R6 linear", 4'd1, 32'h108);
    @(negedge clk);
    check("R2 idle no valid", {31'd0, addrValid}, 32'd0);
  endtask

  task automatic testWrapUp();
    setCtx(4'd2, 32'h1003, 32'd7, 32'd3);
    access("R8 unaligned start", 4'd2, 32'h1003);
    access("R3 step", 4'd2, 32'h1006);
    access("R3 step2", 4'd2, 32'h1009);
    access("R4 wrap up", 4'd2, 32'h1005);
    access("R8 step", 4'd2, 32'h1008);
    access("R4 wrap up again", 4'd2, 32'h1004);
  endtask

  task automatic testWrapDown();
    setCtx(4'd3, 32'h2001, 32'd5, 32'hFFFF_FFFE);
    access("R5 start", 4'd3, 32'h2001);
    access("R5 wrap down", 4'd3, 32'h2004);
    access("R5 step", 4'd3, 32'h2002);
    access("R5 wrap down again", 4'd3, 32'h2005);
    access("R5 step2", 4'd3, 32'h2003);
  endtask

  task automatic testModEqLen();
    setCtx(4'd4, 32'h40, 32'd8, 32'd8);
    wrReg(2'd0, 4'd4, 32'h43);
    access("R12 first", 4'd4, 32'h43);
    access("R12 +len", 4'd4, 32'h43);
    wrReg(2'd1, 4'd4, 32'hFFFF_FFF8);
    access("R12 -len a", 4'd4, 32'h43);
    access("R12 -len b", 4'd4, 32'h43);
  endtask

  task automatic testBanks();
    setCtx(4'd5, 32'h500, 32'd0, 32'd1);
    access("R9 bank0 first", 4'd5, 32'h500);
    setBank(1'b1);
    access("R9 bank1 empty", 4'd5, 32'h0);
    setCtx(4'd5, 32'h900, 32'd0, 32'd2);
    access("R9 bank1 a", 4'd5, 32'h900);
    access("R9 bank1 b", 4'd5, 32'h902);
    setBank(1'b0);
    access("R9 bank0 kept", 4'd5, 32'h501);
    // bankSel and access in the same cycle: old bank serves the access
    @(negedge clk);
    bankSel = 1'b1; accEn = 1'b1; accCtx = 4'd5;
    @(negedge clk);
    accEn = 1'b0;
    check("R9 switch latency", addrOut, 32'h502);
    access("R9 bank1 kept", 4'd5, 32'h904);
    setBank(1'b0);
    access("R9 bank0 resumed", 4'd5, 32'h503);
  endtask

  task automatic testSimd();
    setCtx(4'd6, 32'h600, 32'd0, 32'd2);
    @(negedge clk);
    accEn = 1'b1; accCtx = 4'd6; simdEn = 1'b1;
    @(negedge clk);
    accEn = 1'b0; simdEn = 1'b0;
    check("R10 pairValid", {31'd0, pairValid}, 32'd1);
    check("R10 addrOut", addrOut, 32'h600);
    check("R10 pairAddr", pairAddr, 32'h601);
    access("R10 single", 4'd6, 32'h602);
    check("R10 no pair", {31'd0, pairValid}, 32'd0);
  endtask

  task automatic testPrecedence();
    setCtx(4'd7, 32'h700, 32'd0, 32'd1);
    @(negedge clk);
    accEn = 1'b1; accCtx = 4'd7;
    wrEn = 1'b1; wrField = 2'd0; wrCtx = 4'd7; wrData = 32'h777;
    @(negedge clk);
    accEn = 1'b0; wrEn = 1'b0;
    check("R11 old index out", addrOut, 32'h700);
    access("R11 write wins", 4'd7, 32'h777);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLinear();
    testWrapUp();
    testWrapDown();
    testModEqLen();
    testBanks();
    testSimd();
    testPrecedence();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule